// File: doc/BRIEF.md
# Handshaked Dataflow ALU Element

This block is one processing node of a small dataflow array. An opcode is loaded through a configuration port. From then on the node computes whenever its operands arrive: no instruction is issued per datum. It has two operand links (left and right) and one result link. Each link carries data plus a two-wire handshake. The producer raises *ready* when its data is valid. The receiver answers with *acknowledge* once it has taken the data, and the producer may then release its buffer.

A four-state controller sequences the node. **IDLE** means unconfigured or configured as no-op. **READY** means configured, with an empty output buffer. **BUSY** means computing. **WAIT** means a result is held for a consumer. The internal compute enable is active only in BUSY, so the operand path and the result register do no work in the other states.

The operands are latched on the same edge that detects them, so computing begins with no extra synchronising cycle. Unary operations depend only on the left link. A result stays valid and stable until the consumer acknowledges it. Nodes can therefore be chained into a dependency graph, with no intermediate register file.

Top module: `flow_alu_node`

## Requirements
- R1: After reset the node is in IDLE (`node_state` = 0), with `res_rdy`, `lhs_ack` and `rhs_ack` all low.
- R2: Opcode 0 (no-op) and any code from 8 to 15 put the node in IDLE. In IDLE no operand is ever acknowledged, even while both ready lines are high.
- R3: A configuration write (`cfg_valid` high) is taken only in IDLE or READY. A valid opcode (1 to 7) moves the node to READY on the next edge. A write made in BUSY or WAIT is ignored and changes neither the state nor the active opcode.
- R4: A binary opcode (1 to 4, 6, 7) leaves the node in READY, with no acknowledge on either link, until both `lhs_rdy` and `rhs_rdy` are high at the same edge.
- R5: The unary opcode NOT (5) waits for `lhs_rdy` alone, and `rhs_ack` never rises while it is active.
- R6: At the edge where READY sees its operands, they are latched and the node enters BUSY. Each acknowledge it uses is high for exactly that one BUSY cycle.
- R7: Result per opcode: 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 NOT of left, 6 left+right, 7 left−right. The last two wrap modulo 2^W.
- R8: BUSY lasts one cycle and then WAIT is entered, with `res_rdy` high and `res_data` valid. `res_rdy` and `res_data` stay constant until `res_ack` is high at an edge, and the node then returns to READY.
- R9: `node_state` encodes IDLE=0, READY=1, BUSY=2, WAIT=3. The compute enable is active only in BUSY.
- R10: `res_ack` outside WAIT has no effect on the state or on `res_rdy`.
- R11: In READY, a configuration write at the same edge as operand arrival takes priority. The operands are not taken at that edge, and they are consumed under the new opcode afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_op | input | 4 | Opcode to load |
| lhs_data | input | W | Left operand data |
| lhs_rdy | input | 1 | Left operand valid |
| lhs_ack | output | 1 | Left operand taken (one-cycle pulse) |
| rhs_data | input | W | Right operand data |
| rhs_rdy | input | 1 | Right operand valid |
| rhs_ack | output | 1 | Right operand taken (one-cycle pulse) |
| res_data | output | W | Result data |
| res_rdy | output | 1 | Result valid and held |
| res_ack | input | 1 | Result taken by the consumer |
| node_state | output | 2 | Controller state |

## Verification
A wrong controller state shows on `node_state` and `res_rdy` on the very next edge. It also shows one cycle later as a missing, extra or stretched acknowledge pulse. A wrong active opcode shows up two edges after the operands arrive. It appears either as a wrong value on `res_data` or as a right-link acknowledge that should not occur. A lost hold in WAIT changes `res_data` or drops `res_rdy` before the consumer has acknowledged, and the bench watches for this over several idle cycles.

// File: rtl/flow_alu_pkg.sv
package flow_alu_pkg;

  localparam int OPW = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READY = 2'd1,
    ST_BUSY  = 2'd2,
    ST_WAIT  = 2'd3
  } node_state_t;

  localparam logic [OPW-1:0] OP_NOP  = 4'd0;
  localparam logic [OPW-1:0] OP_OR   = 4'd1;
  localparam logic [OPW-1:0] OP_XOR  = 4'd2;
  localparam logic [OPW-1:0] OP_NAND = 4'd3;
  localparam logic [OPW-1:0] OP_NOR  = 4'd4;
  localparam logic [OPW-1:0] OP_NOT  = 4'd5;
  localparam logic [OPW-1:0] OP_ADD  = 4'd6;
  localparam logic [OPW-1:0] OP_SUB  = 4'd7;

  // Codes 1..7 do work; everything else is a no-op.
  function automatic logic op_active(logic [OPW-1:0] c);
    return (c != OP_NOP) && (c <= OP_SUB);
  endfunction

  // True when the operation consumes the right operand as well.
  function automatic logic op_binary(logic [OPW-1:0] c);
    return op_active(c) && (c != OP_NOT);
  endfunction

endpackage

// File: rtl/flow_alu_ctrl.sv
module flow_alu_ctrl
  import flow_alu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_valid,
  input  logic [OPW-1:0]  cfg_op,
  input  logic            lhs_rdy,
  input  logic            rhs_rdy,
  input  logic            res_ack,
  output node_state_t     state,
  output logic [OPW-1:0]  op_q,
  output logic            take,
  output logic            clk_en,
  output logic            lhs_ack,
  output logic            rhs_ack
);

  node_state_t state_nx;
  logic        cfg_accept;
  logic        need_rhs;

  assign need_rhs   = op_binary(op_q);
  assign cfg_accept = cfg_valid && ((state == ST_IDLE) || (state == ST_READY));
  // Operands are taken only in READY and only when no reconfiguration competes.
  assign take       = (state == ST_READY) && !cfg_valid && lhs_rdy && (rhs_rdy || !need_rhs);
  assign clk_en     = (state == ST_BUSY);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE, ST_READY: begin
        if (cfg_accept)
          state_nx = op_active(cfg_op) ? ST_READY : ST_IDLE;
        else if (take)
          state_nx = ST_BUSY;
      end
      ST_BUSY: state_nx = ST_WAIT;
      ST_WAIT: if (res_ack) state_nx = ST_READY;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_q    <= OP_NOP;
      lhs_ack <= 1'b0;
      rhs_ack <= 1'b0;
    end else begin
      state   <= state_nx;
      if (cfg_accept)
        op_q  <= op_active(cfg_op) ? cfg_op : OP_NOP;
      lhs_ack <= take;
      rhs_ack <= take && need_rhs;
    end
  end

endmodule

// File: rtl/flow_alu_capture.sv
module flow_alu_capture #(
  parameter int W     = 32,
  parameter int NPORT = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      take,
  input  logic [NPORT-1:0][W-1:0]   din,
  output logic [NPORT-1:0][W-1:0]   q
);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q[p] <= '0;
      else if (take) q[p] <= din[p];
    end
  end

endmodule

// File: rtl/flow_alu_exec.sv
module flow_alu_exec
  import flow_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_en,
  input  logic [OPW-1:0]  op,
  input  logic [W-1:0]    lhs,
  input  logic [W-1:0]    rhs,
  output logic [W-1:0]    result
);

  function automatic logic [W-1:0] alu_eval(logic [OPW-1:0] c, logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] r;
    unique case (c)
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_NAND: r = ~(a & b);
      OP_NOR:  r = ~(a | b);
      OP_NOT:  r = ~a;
      OP_ADD:  r = a + b;
      OP_SUB:  r = a - b;
      default: r = '0;
    endcase
    return r;
  endfunction

  // Result buffer only toggles while the controller grants the compute enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      result <= '0;
    else if (clk_en) result <= alu_eval(op, lhs, rhs);
  end

endmodule

// File: rtl/flow_alu_node.sv
module flow_alu_node
  import flow_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_valid,
  input  logic [3:0]      cfg_op,
  input  logic [W-1:0]    lhs_data,
  input  logic            lhs_rdy,
  output logic            lhs_ack,
  input  logic [W-1:0]    rhs_data,
  input  logic            rhs_rdy,
  output logic            rhs_ack,
  output logic [W-1:0]    res_data,
  output logic            res_rdy,
  input  logic            res_ack,
  output logic [1:0]      node_state
);

  localparam int NPORT = 2;

  node_state_t              state;
  logic [OPW-1:0]           op_q;
  logic                     take;
  logic                     clk_en;
  logic [NPORT-1:0][W-1:0]  opnd_in;
  logic [NPORT-1:0][W-1:0]  opnd_q;

  assign opnd_in[0] = lhs_data;
  assign opnd_in[1] = rhs_data;

  flow_alu_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .cfg_op    (cfg_op),
    .lhs_rdy   (lhs_rdy),
    .rhs_rdy   (rhs_rdy),
    .res_ack   (res_ack),
    .state     (state),
    .op_q      (op_q),
    .take      (take),
    .clk_en    (clk_en),
    .lhs_ack   (lhs_ack),
    .rhs_ack   (rhs_ack)
  );

  flow_alu_capture #(.W(W), .NPORT(NPORT)) u_capture (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .din   (opnd_in),
    .q     (opnd_q)
  );

  flow_alu_exec #(.W(W)) u_exec (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_en (clk_en),
    .op     (op_q),
    .lhs    (opnd_q[0]),
    .rhs    (opnd_q[1]),
    .result (res_data)
  );

  assign res_rdy    = (state == ST_WAIT);
  assign node_state = state;

endmodule

// File: rtl/flow_alu_node_chk.sv
module flow_alu_node_chk
  import flow_alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      node_state,
  input logic [OPW-1:0]  op_q,
  input logic            clk_en,
  input logic            lhs_ack,
  input logic            rhs_ack,
  input logic            res_rdy,
  input logic            res_ack,
  input logic [W-1:0]    res_data
);

  assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lhs_ack |=> !lhs_ack);

  assert_rack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rhs_ack |=> !rhs_ack);

  assert_idle_no_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (node_state == 2'd0) |=> (!lhs_ack && !rhs_ack));

  assert_binary_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lhs_ack && op_binary(op_q)) |-> rhs_ack);

  assert_unary_no_rack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rhs_ack |-> op_binary(op_q));

  assert_busy_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (node_state == 2'd2) |=> (node_state == 2'd3));

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_rdy && !res_ack) |=> (res_rdy && $stable(res_data)));

  assert_enable_leads_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |=> res_rdy);

  assert_stray_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_rdy && res_ack && node_state != 2'd2) |=> !res_rdy);

endmodule

bind flow_alu_node flow_alu_node_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .node_state (node_state),
  .op_q       (op_q),
  .clk_en     (clk_en),
  .lhs_ack    (lhs_ack),
  .rhs_ack    (rhs_ack),
  .res_rdy    (res_rdy),
  .res_ack    (res_ack),
  .res_data   (res_data)
);

// File: tb/flow_alu_node_tb.sv
module flow_alu_node_tb;

  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_valid = 1'b0;
  logic [3:0]    cfg_op = 4'd0;
  logic [W-1:0]  lhs_data = '0;
  logic          lhs_rdy = 1'b0;
  logic          lhs_ack;
  logic [W-1:0]  rhs_data = '0;
  logic          rhs_rdy = 1'b0;
  logic          rhs_ack;
  logic [W-1:0]  res_data;
  logic          res_rdy;
  logic          res_ack = 1'b0;
  logic [1:0]    node_state;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  flow_alu_node #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_op(cfg_op),
    .lhs_data(lhs_data), .lhs_rdy(lhs_rdy), .lhs_ack(lhs_ack),
    .rhs_data(rhs_data), .rhs_rdy(rhs_rdy), .rhs_ack(rhs_ack),
    .res_data(res_data), .res_rdy(res_rdy), .res_ack(res_ack),
    .node_state(node_state)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model written from the opcode table.
  function automatic logic [W-1:0] model(logic [3:0] c, logic [W-1:0] a, logic [W-1:0] b);
    case (c)
      4'd1: return ~(~a & ~b);
      4'd2: return (a & ~b) | (~a & b);
      4'd3: return ~a | ~b;
      4'd4: return ~a & ~b;
      4'd5: return a ^ {W{1'b1}};
      4'd6: return W'(a + b);
      4'd7: return W'(a + ~b + 1);
      default: return '0;
    endcase
  endfunction

  function automatic bit binary_op(logic [3:0] c);
    return (c >= 4'd1 && c <= 4'd7 && c != 4'd5);
  endfunction

  task automatic configure(logic [3:0] c, logic [1:0] exp_state);
    @(negedge clk); cfg_valid = 1'b1; cfg_op = c;
    @(negedge clk); cfg_valid = 1'b0;
    check("R3 state after configure", W'(node_state), W'(exp_state));
  endtask

  task automatic consume_result(logic [W-1:0] exp);
    check("R8 result ready", W'(res_rdy), W'(1));
    check("R7 result value", res_data, exp);
    res_ack = 1'b1;
    @(negedge clk); res_ack = 1'b0;
    check("R8 back to READY", W'(node_state), W'(1));
    check("R8 result ready dropped", W'(res_rdy), W'(0));
  endtask

  task automatic run_op(logic [3:0] c, logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] exp;
    bit bin;
    exp = model(c, a, b);
    bin = binary_op(c);
    @(negedge clk); lhs_data = a; rhs_data = b; lhs_rdy = 1'b1; rhs_rdy = bin;
    @(negedge clk);
    check("R9 BUSY state", W'(node_state), W'(2));
    check("R6 left ack pulse", W'(lhs_ack), W'(1));
    check("R5 right ack only when binary", W'(rhs_ack), W'(bin));
    lhs_rdy = 1'b0; rhs_rdy = 1'b0;
    @(negedge clk);
    check("R8 WAIT state", W'(node_state), W'(3));
    check("R6 ack lasts one cycle", W'(lhs_ack | rhs_ack), W'(0));
    for (int i = 0; i < 2; i++) begin
      check("R8 held result", res_data, exp);
      check("R8 held ready", W'(res_rdy), W'(1));
      @(negedge clk);
    end
    consume_result(exp);
  endtask

  task automatic t_reset();
    check("R1 reset state", W'(node_state), W'(0));
    check("R1 reset res_rdy", W'(res_rdy), W'(0));
    check("R1 reset acks", W'({lhs_ack, rhs_ack}), W'(0));
  endtask

  task automatic t_noop(logic [3:0] c);
    configure(c, 2'd0);
    lhs_rdy = 1'b1; rhs_rdy = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R2 no ack in IDLE", W'({lhs_ack, rhs_ack}), W'(0));
      check("R2 stays IDLE", W'(node_state), W'(0));
    end
    lhs_rdy = 1'b0; rhs_rdy = 1'b0;
  endtask

  task automatic t_binary_wait();
    configure(4'd6, 2'd1);
    @(negedge clk); lhs_data = 32'd40; rhs_data = 32'd2; lhs_rdy = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R4 waits for right operand", W'(node_state), W'(1));
      check("R4 no ack yet", W'({lhs_ack, rhs_ack}), W'(0));
    end
    rhs_rdy = 1'b1;
    @(negedge clk);
    check("R4 both acked", W'({lhs_ack, rhs_ack}), W'(3));
    lhs_rdy = 1'b0; rhs_rdy = 1'b0;
    @(negedge clk);
    consume_result(32'd42);
  endtask

  task automatic t_cfg_ignored();
    @(negedge clk); lhs_data = 32'h10; rhs_data = 32'h5; lhs_rdy = 1'b1; rhs_rdy = 1'b1;
    @(negedge clk); lhs_rdy = 1'b0; rhs_rdy = 1'b0;
    cfg_valid = 1'b1; cfg_op = 4'd1;          // write during BUSY
    @(negedge clk);
    check("R3 BUSY write ignored", W'(node_state), W'(3));
    // still asserted during WAIT
    @(negedge clk); cfg_valid = 1'b0;
    check("R3 WAIT write ignored", W'(node_state), W'(3));
    consume_result(32'h15);
    run_op(4'd6, 32'h3, 32'h4);               // still ADD: 7
  endtask

  task automatic t_stray_ack();
    @(negedge clk); res_ack = 1'b1;
    @(negedge clk); res_ack = 1'b0;
    check("R10 stray ack keeps READY", W'(node_state), W'(1));
    check("R10 stray ack no res_rdy", W'(res_rdy), W'(0));
  endtask

  task automatic t_cfg_priority();
    @(negedge clk);
    cfg_valid = 1'b1; cfg_op = 4'd2;
    lhs_data = 32'hF0F0_1234; rhs_data = 32'h0FF0_4321; lhs_rdy = 1'b1; rhs_rdy = 1'b1;
    @(negedge clk); cfg_valid = 1'b0;
    check("R11 config wins, still READY", W'(node_state), W'(1));
    check("R11 no ack at config edge", W'({lhs_ack, rhs_ack}), W'(0));
    @(negedge clk);
    check("R11 taken next edge", W'({lhs_ack, rhs_ack}), W'(3));
    lhs_rdy = 1'b0; rhs_rdy = 1'b0;
    @(negedge clk);
    consume_result(32'hF0F0_1234 ^ 32'h0FF0_4321);
  endtask

  task automatic t_unary();
    configure(4'd5, 2'd1);
    run_op(4'd5, 32'h1234_5678, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_noop(4'd0);
    t_noop(4'd11);
    t_binary_wait();
    t_cfg_ignored();
    t_stray_ack();
    t_cfg_priority();
    configure(4'd1, 2'd1); run_op(4'd1, 32'hA0A0_0000, 32'h0505_00FF);
    configure(4'd3, 2'd1); run_op(4'd3, 32'hFF00_FF00, 32'hF0F0_F0F0);
    configure(4'd4, 2'd1); run_op(4'd4, 32'h8000_0001, 32'h0000_0100);
    configure(4'd6, 2'd1); run_op(4'd6, 32'hFFFF_FFFF, 32'h1);
    configure(4'd7, 2'd1); run_op(4'd7, 32'h0, 32'h1);
    run_op(4'd7, 32'd100, 32'd58);
    t_unary();
    configure(4'd0, 2'd0);                    // back to IDLE from READY
    check("R2 no-op from READY gives IDLE", W'(node_state), W'(0));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule